// File: doc/BRIEF.md
# Audio FIFO status and interrupt unit

This unit sits beside the sample FIFOs of a serial audio controller and keeps track of how full they are. It does not hold any samples. It watches push and pop strobes on each FIFO: the bus side fills the transmit FIFO and drains the receive FIFO, and the serial side does the opposite. From these strobes it keeps an entry count for each FIFO.

Software reads one packed 32-bit status word. The word holds both entry counts, an empty flag and a full flag, two threshold-based service requests, two sticky error flags and a busy flag. Each service request is compared against its own programmable threshold and clears itself when the count crosses back. The error flags stay set until software writes a one to the matching bit of the clear word. Four of the flags can drive a single registered interrupt line, each through its own mask bit.

Top module: `audio_fifo_status`

## Requirements
- R1: While `rst_ni` is low, and with `enable_i` low after reset, the status word reads 0x0000_0001 and `irq_o` is 0.
- R2: Status bits 15:12 give the receive entry count modulo 16, and bits 11:8 give the transmit entry count modulo 16. A full FIFO therefore reads 0 in its field. Bits 31:16 and bit 7 always read 0.
- R3: Bit 1 is 1 when the receive FIFO holds at least one entry. Bit 0 is 1 when the transmit FIFO holds fewer than 16 entries.
- R4: A FIFO holds 16 entries. A push adds one entry and a pop removes one. A pop on an empty FIFO is rejected. A push on a full FIFO is rejected unless a pop happens in the same cycle. A push and a pop that are both accepted in the same cycle leave the count unchanged. A rejected transfer never changes the count.
- R5: Bit 6 (overrun) sets in the cycle after a serial-side receive push is rejected because the receive FIFO is full. It stays set until a clear write with bit 6 equal to 1.
- R6: Bit 5 (underrun) sets in the cycle after a serial-side transmit pop hits an empty transmit FIFO. It stays set until a clear write with bit 5 equal to 1.
- R7: If an error event and a clear of the same flag happen in the same cycle, the flag stays set.
- R8: Bit 4 is 1 exactly when `enable_i` is 1 and the receive count is at least `rx_thresh_i` + 1.
- R9: Bit 3 is 1 exactly when `enable_i` is 1 and the transmit count is at most `tx_thresh_i`.
- R10: Bit 2 equals `enable_i` AND `frame_active_i`.
- R11: `irq_o` is a register. At each clock edge it captures the OR of status bits 6, 5, 4 and 3, each ANDed with the same bit of `int_mask_i`. All other mask bits have no effect.
- R12: A clear write acts only on bits 6 and 5. The error flags are unchanged when `clr_wr_i` is low or when those two bits of `clr_data_i` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Controller enable |
| frame_active_i | input | 1 | Serial frame in progress |
| tx_push_i | input | 1 | Bus-side write into the transmit FIFO |
| tx_pop_i | input | 1 | Serial-side read from the transmit FIFO |
| rx_push_i | input | 1 | Serial-side write into the receive FIFO |
| rx_pop_i | input | 1 | Bus-side read from the receive FIFO |
| tx_thresh_i | input | 4 | Transmit service threshold |
| rx_thresh_i | input | 4 | Receive service threshold |
| int_mask_i | input | 32 | Interrupt mask word (bits 6..3 used) |
| clr_wr_i | input | 1 | Strobe for a write-one-to-clear |
| clr_data_i | input | 32 | Clear data word (bits 6 and 5 used) |
| status_o | output | 32 | Packed status word |
| irq_o | output | 1 | Registered interrupt |

## Verification
The bench drives both FIFOs into full and empty and keeps pushing and popping at those limits. This catches a count that wraps past 16 or drops below 0, and a full FIFO that is mistaken for an empty one because its level field reads 0. Directed steps apply a clear in the same cycle as a fresh overrun, to catch a design where the clear wins. They also write clear words with only unrelated bits set, to catch clear logic that decodes the wrong bits. Random thresholds sit on both sides of each count, so an off-by-one comparison or a swapped comparison on either side shows up as a wrong service request. The interrupt is compared one cycle after the status it comes from, which exposes an output that is combinational or delayed by the wrong number of cycles.

// File: rtl/afs_pkg.sv
package afs_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned LVL_W       = 4;
  localparam int unsigned ST_TNF      = 0;
  localparam int unsigned ST_RNE      = 1;
  localparam int unsigned ST_BSY      = 2;
  localparam int unsigned ST_TSRV     = 3;
  localparam int unsigned ST_RSRV     = 4;
  localparam int unsigned ST_UDR      = 5;
  localparam int unsigned ST_OVR      = 6;
  localparam int unsigned ST_TLVL_LSB = 8;
  localparam int unsigned ST_RLVL_LSB = 12;
  localparam int unsigned N_IRQ       = 4;
  localparam int unsigned IRQ_LSB     = ST_TSRV;
endpackage

// File: rtl/afs_fifo_cnt.sv
module afs_fifo_cnt #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             push_rej_o,
  output logic             pop_rej_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pop_ok, push_ok;

  // a pop in the same cycle frees the slot a push needs
  assign pop_ok  = pop_i && (cnt_q != '0);
  assign push_ok = push_i && ((cnt_q != FULL) || pop_ok);

  always_comb begin
    cnt_d = cnt_q;
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign push_rej_o = push_i && !push_ok;
  assign pop_rej_o  = pop_i && !pop_ok;

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  a_r4_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && cnt_q != '0) |=> $stable(cnt_q));
  a_r4_full_rej: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && cnt_q == FULL) |=> cnt_q == FULL);
  a_r4_empty_rej: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/afs_sticky.sv
module afs_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set dominates clear so a coincident event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/afs_irq.sv
module afs_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flags_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/audio_fifo_status.sv
module audio_fifo_status
  import afs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TH_W  = LVL_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              frame_active_i,
  input  logic              tx_push_i,
  input  logic              tx_pop_i,
  input  logic              rx_push_i,
  input  logic              rx_pop_i,
  input  logic [TH_W-1:0]   tx_thresh_i,
  input  logic [TH_W-1:0]   rx_thresh_i,
  input  logic [WORD_W-1:0] int_mask_i,
  input  logic              clr_wr_i,
  input  logic [WORD_W-1:0] clr_data_i,
  output logic [WORD_W-1:0] status_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam int unsigned N_ERR = 2;
  localparam int unsigned ERR_BIT [N_ERR] = '{ST_OVR, ST_UDR};

  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic tx_push_rej, tx_pop_rej, rx_push_rej, rx_pop_rej;
  logic [N_ERR-1:0] err_set, err_q;
  logic rx_srv, tx_srv;
  logic [WORD_W-1:0] st;

  afs_fifo_cnt #(.DEPTH(DEPTH)) u_tx_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(tx_push_i), .pop_i(tx_pop_i),
    .cnt_o(tx_cnt), .push_rej_o(tx_push_rej), .pop_rej_o(tx_pop_rej)
  );

  afs_fifo_cnt #(.DEPTH(DEPTH)) u_rx_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(rx_push_i), .pop_i(rx_pop_i),
    .cnt_o(rx_cnt), .push_rej_o(rx_push_rej), .pop_rej_o(rx_pop_rej)
  );

  // errors come only from the serial side
  assign err_set[0] = rx_push_rej;
  assign err_set[1] = tx_pop_rej;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    afs_sticky u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (err_set[g]),
      .clr_i (clr_wr_i && clr_data_i[ERR_BIT[g]]),
      .flag_o(err_q[g])
    );
  end

  assign rx_srv = enable_i && (rx_cnt > CNT_W'(rx_thresh_i));
  assign tx_srv = enable_i && (tx_cnt <= CNT_W'(tx_thresh_i));

  always_comb begin
    st = '0;
    st[ST_RLVL_LSB +: LVL_W] = rx_cnt[LVL_W-1:0];
    st[ST_TLVL_LSB +: LVL_W] = tx_cnt[LVL_W-1:0];
    st[ST_OVR]  = err_q[0];
    st[ST_UDR]  = err_q[1];
    st[ST_RSRV] = rx_srv;
    st[ST_TSRV] = tx_srv;
    st[ST_BSY]  = enable_i && frame_active_i;
    st[ST_RNE]  = rx_cnt != '0;
    st[ST_TNF]  = tx_cnt != FULL;
  end

  assign status_o = st;

  afs_irq #(.N(N_IRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flags_i(st[IRQ_LSB +: N_IRQ]),
    .mask_i (int_mask_i[IRQ_LSB +: N_IRQ]),
    .irq_o  (irq_o)
  );

  logic unused_bits;
  assign unused_bits = ^{tx_push_rej, rx_pop_rej, int_mask_i, clr_data_i};

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[WORD_W-1:16] == '0 && !status_o[7]);
  a_r5_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt == FULL && rx_push_i && !rx_pop_i) |=> status_o[ST_OVR]);
  a_r6_udr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt == '0 && tx_pop_i) |=> status_o[ST_UDR]);
  a_r8_r9_srv_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !status_o[ST_RSRV] && !status_o[ST_TSRV]);
  a_r11_irq_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_OVR] && int_mask_i[ST_OVR]) |=> irq_o);
  a_r11_irq_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o[6:3] & int_mask_i[6:3]) == 4'b0) |=> !irq_o);
endmodule

// File: tb/tb_audio_fifo_status.sv
`timescale 1ns/1ps
module tb_audio_fifo_status;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 1'b0, frame_active_i = 1'b0;
  logic tx_push_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [3:0] tx_thresh_i = 4'd0, rx_thresh_i = 4'd0;
  logic [31:0] int_mask_i = '0, clr_data_i = '0;
  logic clr_wr_i = 1'b0;
  logic [31:0] status_o;
  logic irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_tx = 0, m_rx = 0;
  bit m_ovr = 0, m_udr = 0, m_irq = 0;

  always #2.5 clk = ~clk;

  audio_fifo_status dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .frame_active_i(frame_active_i),
    .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i), .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
    .tx_thresh_i(tx_thresh_i), .rx_thresh_i(rx_thresh_i), .int_mask_i(int_mask_i),
    .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i), .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_status();
    logic [31:0] w = '0;
    w[15:12] = 4'(m_rx % 16);
    w[11:8]  = 4'(m_tx % 16);
    w[6] = m_ovr;
    w[5] = m_udr;
    w[4] = enable_i && (m_rx >= int'(rx_thresh_i) + 1);
    w[3] = enable_i && (m_tx <= int'(tx_thresh_i));
    w[2] = enable_i && frame_active_i;
    w[1] = m_rx != 0;
    w[0] = m_tx != 16;
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    logic [31:0] w = exp_status();
    bit tpo, tpu, rpo, rpu;
    m_irq = |(w[6:3] & int_mask_i[6:3]);
    tpo = tx_pop_i && m_tx != 0;
    tpu = tx_push_i && (m_tx != 16 || tpo);
    rpo = rx_pop_i && m_rx != 0;
    rpu = rx_push_i && (m_rx != 16 || rpo);
    if (rx_push_i && !rpu) m_ovr = 1;
    else if (clr_wr_i && clr_data_i[6]) m_ovr = 0;
    if (tx_pop_i && !tpo) m_udr = 1;
    else if (clr_wr_i && clr_data_i[5]) m_udr = 0;
    m_tx = m_tx + int'(tpu) - int'(tpo);
    m_rx = m_rx + int'(rpu) - int'(rpo);
  endtask

  task automatic check_all();
    logic [31:0] e = exp_status();
    chk(status_o[15:8] == e[15:8], "R2 level fields", status_o, e);
    chk(status_o[31:16] == 16'd0 && !status_o[7], "R2 reserved zero", status_o, e);
    chk(status_o[1:0] == e[1:0], "R3 not-empty/not-full", status_o, e);
    chk(status_o[6] == e[6], "R5 overrun flag", status_o, e);
    chk(status_o[5] == e[5], "R6 underrun flag", status_o, e);
    chk(status_o[4] == e[4], "R8 receive service", status_o, e);
    chk(status_o[3] == e[3], "R9 transmit service", status_o, e);
    chk(status_o[2] == e[2], "R10 busy", status_o, e);
    chk(irq_o == m_irq, "R11 interrupt", {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    tx_push_i = 0; tx_pop_i = 0; rx_push_i = 0; rx_pop_i = 0;
    clr_wr_i = 0; clr_data_i = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #12;
    @(negedge clk);
    chk(status_o == 32'h1, "R1 reset status", status_o, 32'h1);
    chk(irq_o == 1'b0, "R1 reset irq", {31'd0, irq_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(status_o == 32'h1, "R1 status after release", status_o, 32'h1);

    enable_i = 1; int_mask_i = 32'h0000_0078; rx_thresh_i = 4'd7; tx_thresh_i = 4'd3;
    // fill receive FIFO to 16
    for (int i = 0; i < 16; i++) begin idle(); rx_push_i = 1; tick(); end
    chk(status_o[15:12] == 4'd0 && status_o[1], "R2 full receive reads level 0", status_o, 32'h0000_0002);
    // push+pop at full: accepted, count held, no overrun
    idle(); rx_push_i = 1; rx_pop_i = 1; tick();
    chk(status_o[6] == 1'b0 && m_rx == 16, "R4 push+pop at full no overrun", status_o, 32'd0);
    // overrun coincident with clear: set wins
    idle(); rx_push_i = 1; clr_wr_i = 1; clr_data_i = 32'h40; tick();
    chk(status_o[6] == 1'b1, "R7 set beats clear", status_o, 32'h40);
    chk(status_o[15:12] == 4'd0 && status_o[1], "R4 rejected push keeps count", status_o, 32'h2);
    // unrelated clear bits and no strobe leave it set
    idle(); clr_wr_i = 1; clr_data_i = 32'hFFFF_FF9F; tick();
    chk(status_o[6] == 1'b1, "R12 other clear bits ignored", status_o, 32'h40);
    idle(); clr_data_i = 32'h60; tick();
    chk(status_o[6] == 1'b1, "R12 clear without strobe ignored", status_o, 32'h40);
    idle(); clr_wr_i = 1; clr_data_i = 32'h40; tick();
    chk(status_o[6] == 1'b0, "R5 overrun cleared", status_o, 32'h0);
    // underrun on empty transmit FIFO, push+pop when empty
    idle(); tx_pop_i = 1; tx_push_i = 1; tick();
    chk(status_o[5] == 1'b1 && status_o[11:8] == 4'd1, "R6 underrun with push", status_o, 32'h120);
    idle(); tx_pop_i = 1; tick();
    idle(); tx_pop_i = 1; tick();
    chk(status_o[5] && status_o[11:8] == 4'd0, "R4 rejected pop keeps count", status_o, 32'h20);
    idle(); clr_wr_i = 1; clr_data_i = 32'h20; tick();
    chk(status_o[5] == 1'b0, "R6 underrun cleared", status_o, 32'h0);
    // drain receive FIFO past empty
    for (int i = 0; i < 18; i++) begin idle(); rx_pop_i = 1; tick(); end
    chk(status_o[1] == 1'b0, "R3 receive empty", status_o, 32'h0);
    // fill transmit FIFO past full
    for (int i = 0; i < 18; i++) begin idle(); tx_push_i = 1; tick(); end
    chk(status_o[0] == 1'b0 && status_o[11:8] == 4'd0, "R3 transmit full", status_o, 32'h0);
    // disabled: service requests forced low
    enable_i = 0; idle(); tick();
    chk(status_o[4:2] == 3'b000, "R8 R9 R10 low when disabled", status_o, 32'h0);
    enable_i = 1;

    // random phases with varying push/pop bias
    for (int ph = 0; ph < 40; ph++) begin
      int bp = int'($urandom_range(10, 90));
      int bq = int'($urandom_range(10, 90));
      int_mask_i = $urandom();
      tx_thresh_i = 4'($urandom()); rx_thresh_i = 4'($urandom());
      for (int c = 0; c < 150; c++) begin
        idle();
        tx_push_i = int'($urandom_range(0, 99)) < bp;
        rx_pop_i  = int'($urandom_range(0, 99)) < bq;
        tx_pop_i  = int'($urandom_range(0, 99)) < bq;
        rx_push_i = int'($urandom_range(0, 99)) < bp;
        frame_active_i = $urandom_range(0, 1) == 1;
        enable_i = $urandom_range(0, 15) != 0;
        if ($urandom_range(0, 19) == 0) begin
          clr_wr_i = 1; clr_data_i = $urandom();
        end
        if ($urandom_range(0, 49) == 0) begin
          tx_thresh_i = 4'($urandom()); rx_thresh_i = 4'($urandom());
        end
        tick();
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule